// File: doc/BRIEF.md
# Pulse-Per-Second Qualifier and Supervisor

This block watches a raw once-per-second timing pulse and judges it against a local free-running tick counter. It first acquires the pulse. Three rising edges are timestamped, and lock is declared only when both intervals between them sit within a tolerance of one nominal second. Once locked, the block forwards only pulses it trusts. A pulse that arrives too soon after the last accepted one is treated as noise and dropped. A pulse that fails to arrive is replaced by a synthetic one when a watchdog runs out. A train of rejected pulses that keeps a steady one-second spacing is taken over as the new reference phase.

On a successful capture the block also reports the frequency error of the local oscillator. This is the number of ticks by which the first-to-third span differs from two nominal seconds. Downstream logic can use it to trim the local timebase. Every threshold (one second, the capture tolerance, the early and late margins and the holdoff after a failed capture) is a parameter counted in local clock ticks.

Top module: `pps_qualifier`

## Requirements
- R1: The pulse input passes through SYNC_N flip-flops and is acted on at its rising edge only, so each low-to-high transition counts as one event however long the input stays high. An accepted pulse appears on `ppsQual` as a one-cycle strobe exactly SYNC_N+1 clock cycles after the input was first sampled high.
- R2: Acquisition timestamps three successive events t1, t2 and t3. Lock is declared at t3 only when both t2−t1 and t3−t2 lie strictly between SEC_TICKS−EPS_TICKS and SEC_TICKS+EPS_TICKS.
- R3: When the acquisition check fails, `captureErr` goes high and all pulses are ignored for HOLD_TICKS cycles. Acquisition then restarts from the first timestamp. `captureErr` clears when a later capture succeeds.
- R4: On a successful capture, `freqErr` becomes the signed value (t3−t1)−2·SEC_TICKS. It holds that value for as long as lock lasts.
- R5: No qualified pulse is produced while `locked` is low. The third acquisition event is itself emitted as a qualified pulse, in the same cycle that `locked` rises.
- R6: While locked, an event whose distance from the last accepted pulse is below SEC_TICKS−DT2_TICKS is rejected and produces no output. An event at or beyond that distance is accepted.
- R7: While locked, if no pulse is accepted within SEC_TICKS+DT1_TICKS cycles of the last accepted pulse, a synthetic qualified pulse is emitted and `lostAlarm` rises. The watchdog then re-arms from that synthetic pulse.
- R8: `lostAlarm` stays high until a real pulse is accepted, which clears it.
- R9: When a real event is accepted in the same cycle the watchdog would expire, exactly one qualified pulse is emitted and `lostAlarm` is not raised.
- R10: Rejected events are timestamped in a separate chain. When three of them in a row are each spaced strictly within EPS_TICKS of one second, the third is emitted as a qualified pulse and becomes the new reference for the watchdog and the noise window.
- R11: A high `restartReq` at a clock edge clears `locked`, `captureErr` and `lostAlarm` and returns the block to the first acquisition step.
- R12: After reset, `ppsQual`, `locked`, `captureErr` and `lostAlarm` are all low and the block waits for the first acquisition event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local tick clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ppsRaw | input | 1 | Unqualified pulse-per-second input |
| restartReq | input | 1 | Drops lock and restarts acquisition |
| ppsQual | output | 1 | One-cycle strobe per qualified pulse |
| locked | output | 1 | Acquisition achieved |
| captureErr | output | 1 | Last acquisition attempt failed |
| lostAlarm | output | 1 | A pulse was replaced by a synthetic one |
| freqErr | output | ERR_W | Signed two-second span error from capture, in ticks |

## Verification
A real pulse driven in bench cycle T shows up as a qualified strobe in cycle T+3: two synchroniser flops and the registered control output. A synthetic pulse is due SEC_TICKS+DT1_TICKS cycles after the previous strobe. The bench drives stimuli on the falling clock edge and counts cycles on the rising edge. For every pulse it must see, its driver pushes the exact expected cycle into a queue. A monitor samples `ppsQual` on each falling edge and flags any strobe that comes early, late, twice or unasked. Level results (`locked`, `captureErr`, `lostAlarm`, `freqErr`) are registered on the same edge as the strobe, so they are checked a few cycles after the strobe that should have changed them, and before the next stimulus can move them again.

// File: rtl/pps_qual_pkg.sv
package pps_qual_pkg;

  typedef enum logic [2:0] {
    ST_FIRST,
    ST_SECOND,
    ST_THIRD,
    ST_HOLD,
    ST_LOCKED
  } qualState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capT1;
    logic capT2;
    logic capLock;
    logic setRef;
    logic capR1;
    logic capR2;
    logic startHold;
  } dpStrobe_t;

  // comparisons from datapath to control
  typedef struct packed {
    logic evt;
    logic okA;
    logic okB;
    logic tooEarly;
    logic expired;
    logic rejOk1;
    logic rejOk2;
    logic holdDone;
  } dpFlags_t;

endpackage

// File: rtl/pps_qual_dp.sv
module pps_qual_dp
  import pps_qual_pkg::*;
#(
  parameter int unsigned TS_W      = 32,
  parameter int unsigned SYNC_N    = 2,
  parameter int unsigned SEC_TICKS = 250_000_000,
  parameter int unsigned EPS_TICKS = 500_000,
  parameter int unsigned DT1_TICKS = 250_000,
  parameter int unsigned DT2_TICKS = 250_000,
  parameter int unsigned HOLD_TICKS = 750_000_000,
  parameter int unsigned ERR_W     = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ppsRaw,
  input  dpStrobe_t               stb,
  output dpFlags_t                flg,
  output logic signed [ERR_W-1:0] freqErr
);

  localparam int unsigned HC_W = $clog2(HOLD_TICKS + 1);
  localparam logic [TS_W-1:0] WIN_LO  = TS_W'(SEC_TICKS - EPS_TICKS);
  localparam logic [TS_W-1:0] WIN_HI  = TS_W'(SEC_TICKS + EPS_TICKS);
  localparam logic [TS_W-1:0] EARLY_B = TS_W'(SEC_TICKS - DT2_TICKS);
  localparam logic [TS_W-1:0] LATE_B  = TS_W'(SEC_TICKS + DT1_TICKS);
  localparam logic [TS_W-1:0] TWO_SEC = TS_W'(2 * SEC_TICKS);
  localparam logic [HC_W-1:0] HOLD_LD = HC_W'(HOLD_TICKS);

  logic [SYNC_N:0]   syncQ;
  logic [TS_W-1:0]   nowCnt;
  logic [TS_W-1:0]   t1Q, t2Q, refQ, rej1Q, rej2Q;
  logic [TS_W-1:0]   sinceRef, span;
  logic [HC_W-1:0]   holdCnt;

  // true when b-to-a lies strictly inside one second +/- tolerance
  function automatic logic nearSec(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = a - b;
    return (d > WIN_LO) && (d < WIN_HI);
  endfunction

  // synchroniser chain plus one extra stage for edge detection
  generate
    for (genvar i = 0; i <= SYNC_N; i++) begin : g_sync
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= ppsRaw;
      end else begin : g_tail
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncQ[i] <= 1'b0;
          else       syncQ[i] <= syncQ[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nowCnt  <= '0;
      t1Q     <= '0;
      t2Q     <= '0;
      refQ    <= '0;
      rej1Q   <= '0;
      rej2Q   <= '0;
      holdCnt <= '0;
      freqErr <= '0;
    end else begin
      nowCnt <= nowCnt + 1'b1;
      if (stb.capT1) t1Q <= nowCnt;
      if (stb.capT2) t2Q <= nowCnt;
      if (stb.setRef || stb.capLock) refQ <= nowCnt;
      if (stb.capR1) rej1Q <= nowCnt;
      if (stb.capR2) rej2Q <= nowCnt;
      if (stb.capLock) freqErr <= $signed(span[ERR_W-1:0]);
      if (stb.startHold)     holdCnt <= HOLD_LD;
      else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    sinceRef     = nowCnt - refQ;
    span         = nowCnt - t1Q - TWO_SEC;
    flg.evt      = syncQ[SYNC_N-1] & ~syncQ[SYNC_N];
    flg.okA      = nearSec(t2Q, t1Q);
    flg.okB      = nearSec(nowCnt, t2Q);
    flg.tooEarly = sinceRef < EARLY_B;
    flg.expired  = sinceRef >= LATE_B;
    flg.rejOk1   = nearSec(nowCnt, rej1Q);
    flg.rejOk2   = nearSec(nowCnt, rej2Q);
    flg.holdDone = (holdCnt == '0);
  end

endmodule

// File: rtl/pps_qual_ctrl.sv
module pps_qual_ctrl
  import pps_qual_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      restartReq,
  input  dpFlags_t  flg,
  output dpStrobe_t stb,
  output logic      ppsQual,
  output logic      locked,
  output logic      captureErr,
  output logic      lostAlarm
);

  qualState_e stQ, stN;
  logic [1:0] rejCntQ, rejCntN;
  logic       pulseN, lockN, errN, almN;
  logic       acceptEvt, rejectEvt;

  always_comb begin
    stb       = '0;
    stN       = stQ;
    rejCntN   = rejCntQ;
    pulseN    = 1'b0;
    lockN     = locked;
    errN      = captureErr;
    almN      = lostAlarm;
    acceptEvt = flg.evt && !flg.tooEarly;
    rejectEvt = flg.evt && flg.tooEarly;

    if (restartReq) begin
      stN     = ST_FIRST;
      lockN   = 1'b0;
      errN    = 1'b0;
      almN    = 1'b0;
      rejCntN = '0;
    end else begin
      unique case (stQ)
        ST_FIRST: if (flg.evt) begin
          stb.capT1 = 1'b1;
          stN       = ST_SECOND;
        end
        ST_SECOND: if (flg.evt) begin
          stb.capT2 = 1'b1;
          stN       = ST_THIRD;
        end
        ST_THIRD: if (flg.evt) begin
          if (flg.okA && flg.okB) begin
            stb.capLock = 1'b1;
            stN         = ST_LOCKED;
            lockN       = 1'b1;
            errN        = 1'b0;
            almN        = 1'b0;
            pulseN      = 1'b1;
            rejCntN     = '0;
          end else begin
            stb.startHold = 1'b1;
            errN          = 1'b1;
            stN           = ST_HOLD;
          end
        end
        ST_HOLD: if (flg.holdDone) stN = ST_FIRST;
        ST_LOCKED: begin
          if (acceptEvt) begin
            stb.setRef = 1'b1;
            pulseN     = 1'b1;
            almN       = 1'b0;
          end else if (flg.expired) begin
            stb.setRef = 1'b1;
            pulseN     = 1'b1;
            almN       = 1'b1;
          end
          if (rejectEvt) begin
            unique case (rejCntQ)
              2'd1: begin
                if (flg.rejOk1) begin
                  stb.capR2 = 1'b1;
                  rejCntN   = 2'd2;
                end else begin
                  stb.capR1 = 1'b1;
                end
              end
              2'd2: begin
                if (flg.rejOk2) begin
                  stb.setRef = 1'b1;
                  pulseN     = 1'b1;
                  almN       = 1'b0;
                  rejCntN    = 2'd0;
                end else begin
                  stb.capR1 = 1'b1;
                  rejCntN   = 2'd1;
                end
              end
              default: begin
                stb.capR1 = 1'b1;
                rejCntN   = 2'd1;
              end
            endcase
          end
        end
        default: stN = ST_FIRST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ        <= ST_FIRST;
      rejCntQ    <= '0;
      ppsQual    <= 1'b0;
      locked     <= 1'b0;
      captureErr <= 1'b0;
      lostAlarm  <= 1'b0;
    end else begin
      stQ        <= stN;
      rejCntQ    <= rejCntN;
      ppsQual    <= pulseN;
      locked     <= lockN;
      captureErr <= errN;
      lostAlarm  <= almN;
    end
  end

endmodule

// File: rtl/pps_qualifier.sv
module pps_qualifier
  import pps_qual_pkg::*;
#(
  parameter int unsigned TS_W       = 32,
  parameter int unsigned SYNC_N     = 2,
  parameter int unsigned SEC_TICKS  = 250_000_000,
  parameter int unsigned EPS_TICKS  = 500_000,
  parameter int unsigned DT1_TICKS  = 250_000,
  parameter int unsigned DT2_TICKS  = 250_000,
  parameter int unsigned HOLD_TICKS = 750_000_000,
  parameter int unsigned ERR_W      = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ppsRaw,
  input  logic                    restartReq,
  output logic                    ppsQual,
  output logic                    locked,
  output logic                    captureErr,
  output logic                    lostAlarm,
  output logic signed [ERR_W-1:0] freqErr
);

  dpStrobe_t stb;
  dpFlags_t  flg;

  pps_qual_dp #(
    .TS_W(TS_W), .SYNC_N(SYNC_N), .SEC_TICKS(SEC_TICKS), .EPS_TICKS(EPS_TICKS),
    .DT1_TICKS(DT1_TICKS), .DT2_TICKS(DT2_TICKS), .HOLD_TICKS(HOLD_TICKS),
    .ERR_W(ERR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ppsRaw(ppsRaw), .stb(stb), .flg(flg), .freqErr(freqErr)
  );

  pps_qual_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .restartReq(restartReq), .flg(flg), .stb(stb),
    .ppsQual(ppsQual), .locked(locked), .captureErr(captureErr), .lostAlarm(lostAlarm)
  );

endmodule

// File: rtl/pps_qual_chk.sv
module pps_qual_chk #(
  parameter int unsigned ERR_W = 24
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    restartReq,
  input logic                    ppsQual,
  input logic                    locked,
  input logic                    captureErr,
  input logic                    lostAlarm,
  input logic signed [ERR_W-1:0] freqErr
);

  assert_no_pulse_unlocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    ppsQual |-> locked);

  assert_lock_clears_err_R3: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !captureErr);

  assert_alarm_with_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lostAlarm) |-> ppsQual);

  assert_alarm_clear_on_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lostAlarm) && locked) |-> ppsQual);

  assert_restart_unlocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !locked);

  assert_freq_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> $stable(freqErr));

endmodule

bind pps_qualifier pps_qual_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .restartReq(restartReq), .ppsQual(ppsQual),
  .locked(locked), .captureErr(captureErr), .lostAlarm(lostAlarm), .freqErr(freqErr)
);

// File: tb/pps_qualifier_tb.sv
module pps_qualifier_tb;

  localparam int SEC  = 200;
  localparam int EPS  = 4;
  localparam int DT1  = 3;
  localparam int DT2  = 3;
  localparam int HOLD = 50;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ppsRaw = 1'b0;
  logic restartReq = 1'b0;
  logic ppsQual, locked, captureErr, lostAlarm;
  logic signed [23:0] freqErr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pps_qualifier #(
    .TS_W(32), .SYNC_N(2), .SEC_TICKS(SEC), .EPS_TICKS(EPS), .DT1_TICKS(DT1),
    .DT2_TICKS(DT2), .HOLD_TICKS(HOLD), .ERR_W(24)
  ) u_dut (
    .clk(clk), .rstN(rstN), .ppsRaw(ppsRaw), .restartReq(restartReq),
    .ppsQual(ppsQual), .locked(locked), .captureErr(captureErr),
    .lostAlarm(lostAlarm), .freqErr(freqErr)
  );

  task automatic waitCyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic expectAt(input int c, input string tag);
    expQ.push_back(c);
    tagQ.push_back(tag);
  endtask

  // drive a two-cycle high pulse at cycle t; qualify says a strobe is due
  task automatic pulse(input int t, input bit qualify, input string tag);
    waitCyc(t);
    if (qualify) expectAt(t + LAT, tag);
    ppsRaw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ppsRaw = 1'b0;
  endtask

  // monitor: every strobe must match the head of the queue
  always @(negedge clk) begin
    if (rstN) begin
      while (expQ.size() > 0 && expQ[0] < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missing strobe: actual none expected cycle %0d", tagQ[0], expQ[0]);
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
      end
      if (ppsQual) begin
        checks++;
        if (expQ.size() > 0 && expQ[0] == cyc) begin
          void'(expQ.pop_front());
          void'(tagQ.pop_front());
        end else begin
          errors++;
          $display("FAIL R5/R6 unexpected strobe: actual cycle %0d expected %0d",
                   cyc, (expQ.size() > 0) ? expQ[0] : -1);
        end
      end
    end
  end

  initial begin
    fork
      begin
        waitCyc(8);
        rstN = 1'b1;
        waitCyc(20);
        // R12 reset state
        check("R12 locked", int'(locked), 0);
        check("R12 captureErr", int'(captureErr), 0);
        check("R12 lostAlarm", int'(lostAlarm), 0);
        check("R12 ppsQual", int'(ppsQual), 0);

        // R3 failed capture: second interval 220 ticks
        pulse(100, 1'b0, "R3");
        pulse(300, 1'b0, "R3");
        pulse(520, 1'b0, "R3");
        waitCyc(530);
        check("R3 captureErr set", int'(captureErr), 1);
        check("R5 unlocked after fail", int'(locked), 0);
        pulse(540, 1'b0, "R3 holdoff");

        // R2 successful capture: intervals 202 and 199, R5 third pulse emitted
        pulse(700, 1'b0, "R2");
        pulse(902, 1'b0, "R2");
        pulse(1101, 1'b1, "R2 R5 lock strobe");
        waitCyc(1110);
        check("R2 locked", int'(locked), 1);
        check("R3 captureErr cleared", int'(captureErr), 0);
        check("R4 freqErr", int'(freqErr), 1);

        // R1 latency, R6 noise rejection
        pulse(1301, 1'b1, "R1");
        pulse(1400, 1'b0, "R6 noise");
        pulse(1502, 1'b1, "R6 accept");

        // R7 lost pulse: synthetic at 1505+SEC+DT1
        expectAt(1505 + SEC + DT1, "R7 synthetic");
        waitCyc(1712);
        check("R7 lostAlarm set", int'(lostAlarm), 1);
        pulse(1906, 1'b1, "R8");
        waitCyc(1915);
        check("R8 lostAlarm cleared", int'(lostAlarm), 0);

        // R9 real pulse coincides with watchdog expiry
        pulse(2109, 1'b1, "R9 single strobe");
        waitCyc(2120);
        check("R9 no alarm", int'(lostAlarm), 0);
        check("R1 lock held", int'(locked), 1);

        // R6 boundary: 196 rejected, then watchdog fires, 197 accepted
        pulse(2305, 1'b0, "R6 below edge");
        expectAt(2112 + SEC + DT1, "R7 rearmed synthetic");
        waitCyc(2320);
        check("R7 alarm again", int'(lostAlarm), 1);
        pulse(2509, 1'b1, "R6 at edge");
        waitCyc(2520);
        check("R8 alarm cleared at edge", int'(lostAlarm), 0);

        // R10 rejected train at half-second offset taken over
        pulse(2609, 1'b0, "R10 rej1");
        pulse(2709, 1'b1, "R10 real");
        pulse(2809, 1'b0, "R10 rej2");
        pulse(2909, 1'b1, "R10 real");
        pulse(3009, 1'b1, "R10 adopt");
        pulse(3109, 1'b0, "R10 old phase now early");
        pulse(3209, 1'b1, "R10 new phase");
        expectAt(3212 + SEC + DT1, "R7 synthetic after adopt");
        waitCyc(3420);
        check("R7 alarm after adopt", int'(lostAlarm), 1);

        // R11 restart
        waitCyc(3500);
        restartReq = 1'b1;
        @(negedge clk);
        restartReq = 1'b0;
        waitCyc(3505);
        check("R11 locked cleared", int'(locked), 0);
        check("R11 alarm cleared", int'(lostAlarm), 0);
        check("R11 captureErr clear", int'(captureErr), 0);
        pulse(3600, 1'b0, "R11 acquiring");
        waitCyc(3700);
        check("R5 no strobe when unlocked", int'(locked), 0);
        check("R1 queue drained", expQ.size(), 0);
      end
      begin
        waitCyc(20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule